// File: doc/BRIEF.md
# Three-Source Interrupt Flag Controller

This block gathers the interrupt events of a small microcontroller core into one request line. Three sources feed it: a one-cycle overflow pulse from a timer, any change on an 8-bit input port, and a falling edge on a dedicated external pin. Each event latches its own pending flag in a status byte. A flag is set even when its source is masked, so software can poll it. A mask byte gates each source, and a global enable gates all of them. The global enable is turned on by enable and return strobes from the core and turned off by a disable strobe or by interrupt acknowledge.

The core reads the status and mask bytes as output ports. A write to the status byte clears every flag whose data bit is 0. A write to the mask byte loads its three low bits. When the external-select input is low, the external pin is treated as plain I/O. Its synchronised value is still driven out, but its edges raise no flag. Both the port and the external pin pass through a synchroniser first.

Top module: `irq_flag_ctrl`

## Requirements
- R1: While `rst` is high and on the first sample after it falls, `flags_o`, `mask_o`, `gie_o` and `irq_o` are all 0.
- R2: A cycle with `tmr_ovf_i` high sets `flags_o[0]` at the next clock edge, whatever the mask or global enable.
- R3: A change in any bit of `port_i` that is present at clock edge k sets `flags_o[1]` at edge k+2, whatever the mask.
- R4: With `ext_sel_i` high, a 1-to-0 transition of `ext_i` present at edge k sets `flags_o[2]` at edge k+2. A 0-to-1 transition sets nothing.
- R5: While `ext_sel_i` is low, edges on `ext_i` never set `flags_o[2]`. In every mode, `ext_io_o` equals the value `ext_i` had two edges earlier.
- R6: A write with `reg_wr_i`=1 and `reg_addr_i`=0 clears each flag whose `reg_wdata_i` bit is 0 and leaves flags with data bit 1 unchanged. An event in the same cycle wins over the clear.
- R7: A write with `reg_addr_i`=1 loads `mask_o[2:0]` from `reg_wdata_i[2:0]`. Bit 0 enables the timer, bit 1 the port and bit 2 the external source. `mask_o[7:3]` and `flags_o[7:3]` stay 0.
- R8: `gie_o` becomes 1 one edge after `gie_set_i`. It becomes 0 one edge after `gie_clr_i` or `irq_ack_i`, and a clear or acknowledge wins over a set.
- R9: `irq_o` after an edge equals 1 exactly when, before that edge, some flag and its mask bit were both 1 and `gie_o` was 1.
- R10: `port_o` equals the value `port_i` had two edges earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tmr_ovf_i | input | 1 | Timer overflow pulse |
| port_i | input | 8 | Asynchronous input port |
| ext_i | input | 1 | Asynchronous external interrupt pin |
| ext_sel_i | input | 1 | 1: pin is an interrupt input, 0: plain I/O |
| gie_set_i | input | 1 | Enable or return strobe from the core |
| gie_clr_i | input | 1 | Disable strobe from the core |
| irq_ack_i | input | 1 | Core accepts the request |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 1 | 0: status byte, 1: mask byte |
| reg_wdata_i | input | 8 | Write data |
| flags_o | output | 8 | Pending flags (bits 2..0) |
| mask_o | output | 8 | Source enables (bits 2..0) |
| gie_o | output | 1 | Global interrupt enable |
| irq_o | output | 1 | Registered interrupt request |
| port_o | output | 8 | Synchronised port value |
| ext_io_o | output | 1 | Synchronised external pin value |

## Verification
Results arrive at different delays. The timer flag, the register writes and the global enable are due one edge after their stimulus, and pin-driven flags and the synchronised pin outputs two edges after it. The request line follows the flag, mask and enable state by one more edge. The bench model delays the pins through a history queue of matching depth and applies every other stimulus at the modelled edge. It drives inputs on the falling clock edge and compares every output with the model on the next falling edge, half a period after the rising edge that updates the design. Directed sequences cover clear-versus-event and clear-versus-set collisions, ignored edges in I/O mode, and rising edges on the external pin. A pseudo-random phase then mixes all inputs.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NUM_SRC = 3;

  typedef enum logic [1:0] {
    SRC_TMR  = 2'd0,
    SRC_PORT = 2'd1,
    SRC_EXT  = 2'd2
  } src_e;

  typedef struct packed {
    logic ext;
    logic port;
    logic tmr;
  } src_vec_t;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain[0] <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) begin
          chain <= '0;
        end else begin
          chain[0] <= d;
          for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/irq_evt_det.sv
module irq_evt_det #(
  parameter int PORT_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PORT_W-1:0] port_s,
  input  logic              ext_s,
  input  logic              ext_sel,
  output logic              port_chg,
  output logic              ext_fall
);
  logic [PORT_W-1:0] port_prev;
  logic              ext_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      port_prev <= '0;
      ext_prev  <= 1'b0;
    end else begin
      port_prev <= port_s;
      ext_prev  <= ext_s;
    end
  end

  assign port_chg = |(port_s ^ port_prev);
  assign ext_fall = ext_sel & ext_prev & ~ext_s;
endmodule

// File: rtl/irq_gie.sv
module irq_gie (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  input  logic ack_i,
  output logic gie_q
);
  always_ff @(posedge clk) begin
    if (rst)                gie_q <= 1'b0;
    else if (clr_i | ack_i) gie_q <= 1'b0;
    else if (set_i)         gie_q <= 1'b1;
  end
endmodule

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl
  import irq_pkg::*;
#(
  parameter int PORT_W      = 8,
  parameter int REG_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tmr_ovf_i,
  input  logic [PORT_W-1:0] port_i,
  input  logic              ext_i,
  input  logic              ext_sel_i,
  input  logic              gie_set_i,
  input  logic              gie_clr_i,
  input  logic              irq_ack_i,
  input  logic              reg_wr_i,
  input  logic              reg_addr_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  flags_o,
  output logic [REG_W-1:0]  mask_o,
  output logic              gie_o,
  output logic              irq_o,
  output logic [PORT_W-1:0] port_o,
  output logic              ext_io_o
);
  localparam int PAD_W = REG_W - NUM_SRC;

  logic [PORT_W:0] sync_in, sync_out;
  logic            port_chg, ext_fall;
  src_vec_t        flags_q, mask_q, events, clr_vec;
  logic            irq_q;

  assign sync_in = {ext_i, port_i};

  irq_sync #(.W(PORT_W + 1), .STAGES(SYNC_STAGES)) sync_i (
    .clk (clk), .rst (rst), .d (sync_in), .q (sync_out)
  );

  irq_evt_det #(.PORT_W(PORT_W)) det_i (
    .clk      (clk),
    .rst      (rst),
    .port_s   (sync_out[PORT_W-1:0]),
    .ext_s    (sync_out[PORT_W]),
    .ext_sel  (ext_sel_i),
    .port_chg (port_chg),
    .ext_fall (ext_fall)
  );

  irq_gie gie_i (
    .clk   (clk),
    .rst   (rst),
    .set_i (gie_set_i),
    .clr_i (gie_clr_i),
    .ack_i (irq_ack_i),
    .gie_q (gie_o)
  );

  always_comb begin
    events      = '0;
    events.tmr  = tmr_ovf_i;
    events.port = port_chg;
    events.ext  = ext_fall;
    clr_vec     = '0;
    if (reg_wr_i && !reg_addr_i) clr_vec = ~reg_wdata_i[NUM_SRC-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= '0;
      mask_q  <= '0;
      irq_q   <= 1'b0;
    end else begin
      flags_q <= (flags_q & ~clr_vec) | events;
      if (reg_wr_i && reg_addr_i) mask_q <= reg_wdata_i[NUM_SRC-1:0];
      irq_q   <= (|(flags_q & mask_q)) & gie_o;
    end
  end

  assign flags_o  = {{PAD_W{1'b0}}, flags_q};
  assign mask_o   = {{PAD_W{1'b0}}, mask_q};
  assign irq_o    = irq_q;
  assign port_o   = sync_out[PORT_W-1:0];
  assign ext_io_o = sync_out[PORT_W];
endmodule

// File: rtl/irq_flag_ctrl_chk.sv
module irq_flag_ctrl_chk #(
  parameter int PORT_W = 8,
  parameter int REG_W  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              tmr_ovf_i,
  input logic              ext_sel_i,
  input logic              gie_set_i,
  input logic              gie_clr_i,
  input logic              irq_ack_i,
  input logic [REG_W-1:0]  flags_o,
  input logic [REG_W-1:0]  mask_o,
  input logic              gie_o,
  input logic              irq_o
);
  logic rst_seen;
  always_ff @(posedge clk) rst_seen <= rst;

  always_ff @(posedge clk) begin
    if (rst_seen && !rst) begin
      AST_RESET_IDLE: assert (flags_o == '0 && mask_o == '0 && !gie_o && !irq_o); // R1
    end
  end

  AST_TMR_SETS: assert property (@(posedge clk) disable iff (rst)
    tmr_ovf_i |=> flags_o[0]); // R2

  AST_EXT_NEEDS_SEL: assert property (@(posedge clk) disable iff (rst)
    $rose(flags_o[2]) |-> $past(ext_sel_i)); // R5

  AST_GIE_CLR_WINS: assert property (@(posedge clk) disable iff (rst)
    (gie_clr_i || irq_ack_i) |=> !gie_o); // R8

  AST_GIE_SET: assert property (@(posedge clk) disable iff (rst)
    (gie_set_i && !gie_clr_i && !irq_ack_i) |=> gie_o); // R8

  AST_IRQ_NEEDS_GIE: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> $past(gie_o)); // R9
endmodule

bind irq_flag_ctrl irq_flag_ctrl_chk #(.PORT_W(PORT_W), .REG_W(REG_W)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .tmr_ovf_i (tmr_ovf_i),
  .ext_sel_i (ext_sel_i),
  .gie_set_i (gie_set_i),
  .gie_clr_i (gie_clr_i),
  .irq_ack_i (irq_ack_i),
  .flags_o   (flags_o),
  .mask_o    (mask_o),
  .gie_o     (gie_o),
  .irq_o     (irq_o)
);

// File: tb/irq_flag_ctrl_tb_top.sv
`timescale 1ns/1ps
module irq_flag_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tmr_ovf_i = 0, ext_i = 0, ext_sel_i = 0;
  logic       gie_set_i = 0, gie_clr_i = 0, irq_ack_i = 0;
  logic       reg_wr_i = 0, reg_addr_i = 0;
  logic [7:0] reg_wdata_i = 0, port_i = 0;
  logic [7:0] flags_o, mask_o, port_o;
  logic       gie_o, irq_o, ext_io_o;

  int compared = 0, mismatched = 0;

  always #4 clk = ~clk;

  irq_flag_ctrl dut_i (
    .clk(clk), .rst(rst), .tmr_ovf_i(tmr_ovf_i), .port_i(port_i),
    .ext_i(ext_i), .ext_sel_i(ext_sel_i), .gie_set_i(gie_set_i),
    .gie_clr_i(gie_clr_i), .irq_ack_i(irq_ack_i), .reg_wr_i(reg_wr_i),
    .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i), .flags_o(flags_o),
    .mask_o(mask_o), .gie_o(gie_o), .irq_o(irq_o), .port_o(port_o),
    .ext_io_o(ext_io_o)
  );

  // behavioural reference
  logic [7:0] pin_hist[$];
  logic       ext_hist[$];
  logic [2:0] m_flags = 0, m_mask = 0;
  logic       m_gie = 0, m_irq = 0;

  initial begin
    pin_hist = '{8'h00, 8'h00, 8'h00};
    ext_hist = '{1'b0, 1'b0, 1'b0};
  end

  always @(posedge clk) begin
    logic [2:0] ev, wipe;
    if (rst) begin
      m_flags = 0; m_mask = 0; m_gie = 0; m_irq = 0;
      pin_hist = '{8'h00, 8'h00, 8'h00};
      ext_hist = '{1'b0, 1'b0, 1'b0};
    end else begin
      ev[0] = tmr_ovf_i;
      ev[1] = (pin_hist[1] != pin_hist[2]);
      ev[2] = ext_sel_i && ext_hist[2] && !ext_hist[1];
      wipe  = (reg_wr_i && !reg_addr_i) ? ~reg_wdata_i[2:0] : 3'b000;
      m_irq = ((m_flags & m_mask) != 0) && m_gie;
      m_flags = (m_flags & ~wipe) | ev;
      if (reg_wr_i && reg_addr_i) m_mask = reg_wdata_i[2:0];
      if (gie_clr_i || irq_ack_i) m_gie = 0;
      else if (gie_set_i)         m_gie = 1;
      pin_hist.push_front(port_i); void'(pin_hist.pop_back());
      ext_hist.push_front(ext_i);  void'(ext_hist.pop_back());
    end
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
    end
  endtask

  // compare every cycle, away from the rising edge
  always @(negedge clk) begin
    if (!rst) begin
      chk("R2 timer flag",  {7'd0, flags_o[0]}, {7'd0, m_flags[0]});
      chk("R3 port flag",   {7'd0, flags_o[1]}, {7'd0, m_flags[1]});
      chk("R4 ext flag",    {7'd0, flags_o[2]}, {7'd0, m_flags[2]});
      chk("R7 mask",        mask_o, {5'd0, m_mask});
      chk("R7 flag pad",    {flags_o[7:3], 3'd0}, 8'd0);
      chk("R8 gie",         {7'd0, gie_o}, {7'd0, m_gie});
      chk("R9 irq",         {7'd0, irq_o}, {7'd0, m_irq});
      chk("R10 port sync",  port_o, pin_hist[1]);
      chk("R5 ext io",      {7'd0, ext_io_o}, {7'd0, ext_hist[1]});
    end
  end

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    reg_wr_i = 1; reg_addr_i = a; reg_wdata_i = d;
    step();
    reg_wr_i = 0;
  endtask

  initial begin : watchdog
    #(8 * 100000);
    mismatched++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    step(3);
    chk("R1 reset flags", flags_o, 8'd0);
    chk("R1 reset irq",   {6'd0, gie_o, irq_o}, 8'd0);
    rst = 0;
    step();
    chk("R1 post-reset", {mask_o[2:0], flags_o[2:0], gie_o, irq_o}, 8'd0);

    tmr_ovf_i = 1; step(); tmr_ovf_i = 0;
    chk("R2 flag set while masked", {7'd0, flags_o[0]}, 8'd1);
    wr(0, 8'hFE);
    chk("R6 write 0 clears", {5'd0, flags_o[2:0]}, 8'd0);

    port_i = 8'h80; step(3);
    port_i = 8'h81; step(3);
    port_i = 8'h7E; step(3);
    wr(0, 8'hFD);

    ext_sel_i = 0; ext_i = 1; step(3); ext_i = 0; step(3);
    chk("R5 ignored in io mode", {7'd0, flags_o[2]}, 8'd0);
    ext_sel_i = 1; ext_i = 1; step(3);
    chk("R4 rising ignored", {7'd0, flags_o[2]}, 8'd0);
    ext_i = 0; step(3);

    tmr_ovf_i = 1; step(); tmr_ovf_i = 0;
    wr(0, 8'hFB);
    chk("R6 write 1 keeps", {5'd0, flags_o[2:0]}, 8'd1);
    tmr_ovf_i = 1; reg_wr_i = 1; reg_addr_i = 0; reg_wdata_i = 8'h00;
    step(); tmr_ovf_i = 0; reg_wr_i = 0;
    chk("R6 event beats clear", {5'd0, flags_o[2:0]}, 8'd1);

    wr(1, 8'hFF);
    gie_set_i = 1; step(); gie_set_i = 0; step(2);
    irq_ack_i = 1; step(); irq_ack_i = 0; step(2);
    gie_set_i = 1; gie_clr_i = 1; step(); gie_set_i = 0; gie_clr_i = 0;
    gie_set_i = 1; step(); gie_set_i = 0;
    wr(1, 8'h02); step(2); wr(0, 8'h00); step(3);

    lfsr = 16'hACE1;
    for (int c = 0; c < 2000; c++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      tmr_ovf_i   = (lfsr[3:0] == 4'h5);
      port_i      = lfsr[1:0] == 2'b00 ? lfsr[15:8] : port_i;
      ext_i       = lfsr[4];
      ext_sel_i   = lfsr[9] | lfsr[6];
      gie_set_i   = (lfsr[7:5] == 3'b101);
      gie_clr_i   = (lfsr[10:8] == 3'b011);
      irq_ack_i   = irq_o && lfsr[11];
      reg_wr_i    = (lfsr[14:12] == 3'b110);
      reg_addr_i  = lfsr[2];
      reg_wdata_i = lfsr[7:0] ^ lfsr[15:8];
      step();
    end
    {tmr_ovf_i, gie_set_i, gie_clr_i, irq_ack_i, reg_wr_i} = '0;
    step(4);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule